// File: doc/BRIEF.md
# Colour Lookup Table with Streamed Component Writes

This block holds a colour lookup table of 256 entries, each entry a red, green and blue component of 4 bits. A host loads it through a byte-wide port that has two registers, picked by one select line. A byte written to the index register picks an entry. Bytes written after that to the data register fill that entry one component at a time: first red, then green, then blue. The block keeps an internal phase to steer each byte to its component.

After the blue byte, the index steps to the next entry and the phase goes back to red. A host can therefore load the whole table with one index write followed by a stream of data bytes. A separate pixel port reads a full 12-bit colour for any index, with one cycle of latency, for a display pipeline.

Top module: `clut_seq_port`

## Requirements
- R1: After synchronous reset, every entry reads zero on the pixel port, the write index is 0 and the next component is red. `pix_rgb` is 0 while reset is held.
- R2: A host write with `host_sel`=0 loads the write index from `host_wdata[7:0]` and sets the next component to red.
- R3: Host writes with `host_sel`=1 store into the selected entry in the fixed order red, green, blue. Each one stores bits [7:4] of `host_wdata` into the component that is due.
- R4: After the blue write, the write index goes up by one and the next component is red. Index 255 wraps to 0.
- R5: An index write in the middle of a triple restarts at red for the new entry. Components already written to the old entry keep their values.
- R6: `pix_rgb` shows the entry addressed by `pix_idx` at the previous rising clock edge. Red is in bits [11:8], green in [7:4] and blue in [3:0].
- R7: If a host write and a pixel read hit the same entry in the same cycle, the read returns the value from before the write.
- R8: While `host_we` is 0, changes on `host_sel` and `host_wdata` alter neither the table, the write index nor the component phase.
- R9: Bits [3:0] of a data byte have no effect on the stored component.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| host_we | input | 1 | Host write strobe, one byte per cycle |
| host_sel | input | 1 | 0 selects the index register, 1 selects the data register |
| host_wdata | input | 8 | Host write byte |
| pix_idx | input | 8 | Pixel-side read index |
| pix_rgb | output | 12 | Registered colour {red, green, blue} |

## Verification
The assertions assume the following about the inputs:
- `host_sel` and `host_wdata` matter only in cycles where `host_we` is high.
- The internal phase only ever holds one of its three legal values.
- Reset is held for at least one clock edge.

The stimulus keeps to these assumptions:
- It changes every input half a cycle away from the rising edge.
- It pulses `host_we` for exactly one cycle per byte.
- It toggles the select and data lines only while the strobe is low, to probe R8.

// File: rtl/clut_pkg.sv
package clut_pkg;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } comp_phase_e;

    typedef struct packed {
        logic red;
        logic grn;
        logic blu;
    } comp_sel_t;

    localparam int NUM_COMP = 3;

    function automatic comp_phase_e phase_after(input comp_phase_e cur);
        case (cur)
            PH_RED:  return PH_GRN;
            PH_GRN:  return PH_BLU;
            default: return PH_RED;
        endcase
    endfunction

    function automatic comp_sel_t phase_decode(input comp_phase_e cur, input logic en);
        comp_sel_t s;
        s.red = en && (cur == PH_RED);
        s.grn = en && (cur == PH_GRN);
        s.blu = en && (cur == PH_BLU);
        return s;
    endfunction

endpackage

// File: rtl/clut_phase_seq.sv
module clut_phase_seq
    import clut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             index_wr,
    input  logic             data_wr,
    input  logic [IDX_W-1:0] index_val,
    output logic [IDX_W-1:0] wr_idx,
    output comp_phase_e      wr_phase
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx   <= '0;
            wr_phase <= PH_RED;
        end else if (index_wr) begin
            wr_idx   <= index_val;
            wr_phase <= PH_RED;
        end else if (data_wr) begin
            wr_phase <= phase_after(wr_phase);
            if (wr_phase == PH_BLU) begin
                wr_idx <= wr_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/clut_byte_steer.sv
module clut_byte_steer
    import clut_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int COMP_W = 4
) (
    input  logic              data_wr,
    input  comp_phase_e       wr_phase,
    input  logic [DATA_W-1:0] wdata,
    output comp_sel_t         comp_we,
    output logic [COMP_W-1:0] comp_val
);

    always_comb begin
        comp_we  = phase_decode(wr_phase, data_wr);
        comp_val = wdata[DATA_W-1 -: COMP_W];
    end

endmodule

// File: rtl/clut_store.sv
module clut_store
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  comp_sel_t                  comp_we,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [COMP_W-1:0]          comp_val,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [NUM_COMP*COMP_W-1:0] rd_rgb
);

    localparam int DEPTH = 1 << IDX_W;

    logic [NUM_COMP-1:0] we_vec;
    assign we_vec = {comp_we.red, comp_we.grn, comp_we.blu};

    for (genvar k = 0; k < NUM_COMP; k++) begin : g_bank
        logic [COMP_W-1:0] bank [DEPTH];
        logic [COMP_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int e = 0; e < DEPTH; e++) begin
                    bank[e] <= '0;
                end
                rd_q <= '0;
            end else begin
                rd_q <= bank[rd_idx];
                if (we_vec[k]) begin
                    bank[wr_idx] <= comp_val;
                end
            end
        end

        assign rd_rgb[k*COMP_W +: COMP_W] = rd_q;
    end

endmodule

// File: rtl/clut_seq_port.sv
module clut_seq_port
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8,
    parameter int COMP_W = 4,
    localparam int RGB_W = NUM_COMP * COMP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic              host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [IDX_W-1:0]  pix_idx,
    output logic [RGB_W-1:0]  pix_rgb
);

    logic              index_wr;
    logic              data_wr;
    logic [IDX_W-1:0]  cur_idx;
    comp_phase_e       cur_phase;
    comp_sel_t         comp_we;
    logic [COMP_W-1:0] comp_val;

    assign index_wr = host_we && !host_sel;
    assign data_wr  = host_we && host_sel;

    clut_phase_seq #(.IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .index_wr  (index_wr),
        .data_wr   (data_wr),
        .index_val (host_wdata[IDX_W-1:0]),
        .wr_idx    (cur_idx),
        .wr_phase  (cur_phase)
    );

    clut_byte_steer #(.DATA_W(DATA_W), .COMP_W(COMP_W)) u_steer (
        .data_wr  (data_wr),
        .wr_phase (cur_phase),
        .wdata    (host_wdata),
        .comp_we  (comp_we),
        .comp_val (comp_val)
    );

    clut_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .comp_we  (comp_we),
        .wr_idx   (cur_idx),
        .comp_val (comp_val),
        .rd_idx   (pix_idx),
        .rd_rgb   (pix_rgb)
    );

endmodule

// File: rtl/clut_seq_port_chk.sv
module clut_seq_port_chk #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             host_we,
    input logic             host_sel,
    input logic [IDX_W-1:0] cur_idx,
    input logic [1:0]       cur_phase
);

    a_r2_index_restarts_red: assert property (@(posedge clk) disable iff (rst)
        (host_we && !host_sel) |=> (cur_phase == 2'd0));

    a_r3_red_then_green: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_sel && cur_phase == 2'd0) |=> (cur_phase == 2'd1));

    a_r3_green_then_blue: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_sel && cur_phase == 2'd1) |=> (cur_phase == 2'd2));

    a_r4_blue_steps_index: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_sel && cur_phase == 2'd2)
        |=> (cur_phase == 2'd0 && cur_idx == $past(cur_idx) + 1'b1));

    a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !host_we |=> ($stable(cur_idx) && $stable(cur_phase)));

    a_r3_phase_legal: assert property (@(posedge clk) disable iff (rst)
        cur_phase != 2'd3);

endmodule

bind clut_seq_port clut_seq_port_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .host_we   (host_we),
    .host_sel  (host_sel),
    .cur_idx   (cur_idx),
    .cur_phase (cur_phase)
);

// File: tb/clut_seq_port_tb.sv
module clut_seq_port_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  pix_idx = '0;
    logic [11:0] pix_rgb;

    int total = 0;
    int bad = 0;

    logic [3:0] m_r [256];
    logic [3:0] m_g [256];
    logic [3:0] m_b [256];
    int m_idx = 0;
    int m_ph = 0;

    always #5 clk = ~clk;

    clut_seq_port u_dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .pix_idx(pix_idx), .pix_rgb(pix_rgb)
    );

    function automatic logic [11:0] exp_rgb(input int i);
        return {m_r[i], m_g[i], m_b[i]};
    endfunction

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_data(input logic [7:0] v);
        case (m_ph)
            0: m_r[m_idx] = v[7:4];
            1: m_g[m_idx] = v[7:4];
            default: m_b[m_idx] = v[7:4];
        endcase
        if (m_ph == 2) begin
            m_ph = 0;
            m_idx = (m_idx + 1) % 256;
        end else begin
            m_ph++;
        end
    endtask

    task automatic wr_index(input logic [7:0] v);
        @(negedge clk);
        host_we = 1'b1; host_sel = 1'b0; host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
        m_idx = v; m_ph = 0;
    endtask

    task automatic wr_data(input logic [7:0] v);
        @(negedge clk);
        host_we = 1'b1; host_sel = 1'b1; host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
        model_data(v);
    endtask

    task automatic rd_check(input string req, input int i);
        @(negedge clk);
        pix_idx = 8'(i);
        @(negedge clk);
        check(req, pix_rgb, exp_rgb(i));
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            m_r[i] = '0; m_g[i] = '0; m_b[i] = '0;
        end
        repeat (3) @(negedge clk);
        check("R1 output in reset", pix_rgb, 12'h000);
        rst = 1'b0;

        // R1: whole table zero after reset
        for (int i = 0; i < 256; i++) rd_check("R1 cleared entry", i);

        // R1: data write with no index write lands in entry 0 red
        wr_data(8'hD0);
        rd_check("R1 default index/phase", 0);

        // R2 R3 R4 R9 R6: stream full table after one index write
        wr_index(8'h00);
        for (int i = 0; i < 256; i++) begin
            for (int c = 0; c < 3; c++) begin
                wr_data(8'((((i * 7 + c * 5 + 3) & 15) << 4) | ((i + c) & 15)));
            end
        end
        for (int i = 0; i < 256; i++) rd_check("R3 R4 R6 R9 streamed entry", i);

        // R4: index 255 wraps to 0
        wr_index(8'hFF);
        wr_data(8'h1F); wr_data(8'h2E); wr_data(8'h3D);
        wr_data(8'h4C);
        rd_check("R4 last entry", 255);
        rd_check("R4 wrap to entry 0", 0);

        // R5: index write mid-triple
        wr_index(8'd10);
        wr_data(8'hA5);
        wr_index(8'd20);
        wr_data(8'hB0); wr_data(8'hC0);
        rd_check("R5 old entry partial", 10);
        rd_check("R5 new entry restarts red", 20);

        // R2: index from mid-range value, followed by a full triple
        wr_index(8'd77);
        wr_data(8'h90); wr_data(8'h80); wr_data(8'h70);
        rd_check("R2 loaded index", 77);

        // R8: idle cycles with changing select/data
        wr_index(8'd30);
        wr_data(8'hE1);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            host_sel = k[0]; host_wdata = 8'(k * 37);
        end
        rd_check("R8 entry untouched while idle", 30);
        wr_data(8'h62); wr_data(8'h53);
        rd_check("R8 phase held across idle", 30);
        rd_check("R8 neighbour untouched", 31);

        // R7: simultaneous write and read of same entry
        wr_index(8'd40);
        wr_data(8'h10); wr_data(8'h20);
        begin
            logic [11:0] old_v;
            old_v = exp_rgb(40);
            @(negedge clk);
            host_we = 1'b1; host_sel = 1'b1; host_wdata = 8'hF0; pix_idx = 8'd40;
            @(negedge clk);
            host_we = 1'b0;
            model_data(8'hF0);
            check("R7 read returns old value", pix_rgb, old_v);
        end
        rd_check("R7 new value next read", 40);

        // R6: a few scattered reads back to back
        rd_check("R6 read a", 3);
        rd_check("R6 read b", 128);
        rd_check("R6 read c", 254);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule